// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block provides two 8-bit count halves that can run apart or joined into one 16-bit count. A fixed divide-by-four stage and an 8-bit programmable stage sit in front of the halves and turn the instruction-cycle enable into a timer tick. A two-bit mode field picks how the halves are fed. They can be two prescaled timers. The low half can be a timer while the high half counts external events. The halves can also be joined into one 16-bit prescaled timer or one 16-bit event counter.

Each half compares its count with a match value. When a half increments while its count equals the match value, it returns to zero and raises its own interrupt flag. Software sets the block up through a write-only register port. It clears a flag by writing a one to that flag's bit, and it starts and stops counting through a run register. Filtering of the event pin, clock generation and the processor are outside the block.

Top module: `dual_byte_timer`

## Requirements
- R1: After reset both interrupt flags are 0, the mode is 0, the block is stopped, and the counts and prescaler are zero.
- R2: While running, the prescaler produces one tick for every 4*(P+1) clock cycles that have `cyc_en` high, where P is the reload value written at address 1. Cycles with `cyc_en` low do not advance it.
- R3: A half that increments while its count equals its match value goes to zero and sets its flag, so a flag first rises on the (M+1)-th increment from zero. The low match is at address 2 and the high match at address 3.
- R4: Mode 0 (address 0, bits 1:0 = 0) increments each half once per prescaler tick, and each half has its own match value and flag.
- R5: In mode 1 the low half counts prescaler ticks. The high half counts rising edges of `ext_evt` after two synchronising flops, and ticks do not advance it.
- R6: Mode 2 joins the halves into one 16-bit count, with the high half as the upper byte, that advances per tick. It matches {match hi, match lo} and raises only `irq_hi`.
- R7: Mode 3 joins the halves into one 16-bit count of `ext_evt` rising edges. Ticks do not advance it, and it raises only `irq_hi`.
- R8: A count that is above its match value wraps from all ones to zero and matches on the next pass.
- R9: A write to address 4 clears `irq_lo` where bit 0 is 1 and `irq_hi` where bit 1 is 1. Zero bits leave the flags unchanged, and a flag set in the same cycle wins.
- R10: A write to address 0 loads the mode, clears both halves and the prescaler, and stops the block. The flags keep their value.
- R11: Address 5 bit 0 is the run control. While it is 0 the counts and the prescaler hold their values, and they resume from those values when it is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable for the prescaler |
| ext_evt | input | 1 | External event input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| irq_lo | output | 1 | Low-half interrupt flag |
| irq_hi | output | 1 | High-half interrupt flag |

## Verification
The counts and the prescaler state are visible only through the flags, so any wrong internal state shows up as a flag rising at the wrong time. A prescaler or count that is off by one moves the first rise by exactly one tick period. The bench therefore measures the cycle of the first rise exactly instead of only checking that a flag appears. A half fed from the wrong source, or a count that is cleared when it should hold, shows up either as a flag in a mode where it must stay low or as a rise many cycles early. In the wraparound case, a count that saturates or reloads instead of wrapping keeps the flag silent for the whole window.

// File: rtl/tmr_pkg.sv
// Shared definitions for the multi-mode timer/counter.
// Assumes a single clock domain; addresses are fixed by software convention.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'd0,   // two prescaled 8-bit timers
        MODE_MIXED  = 2'd1,   // low timer, high event counter
        MODE_WIDE_T = 2'd2,   // 16-bit prescaled timer
        MODE_WIDE_C = 2'd3    // 16-bit event counter
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_MLO    = 3'd2;
    localparam logic [ADDR_W-1:0] A_MHI    = 3'd3;
    localparam logic [ADDR_W-1:0] A_FCLR   = 3'd4;
    localparam logic [ADDR_W-1:0] A_RUN    = 3'd5;
endpackage

// File: rtl/tmr_prescaler.sv
// Two-stage prescaler: a fixed power-of-two divider feeding a programmable
// divide-by-(reload+1) stage. Emits a one-cycle tick. Assumes en_i already
// includes the run control.
module tmr_prescaler #(
    parameter int FIX_W = 2,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] reload_i,
    output logic             tick_o
);
    logic [FIX_W-1:0] fix_q;
    logic [PRE_W-1:0] pre_q;
    logic             fix_wrap;

    assign fix_wrap = &fix_q;
    assign tick_o   = en_i && fix_wrap && (pre_q == reload_i);

    // Advance the fixed and programmable stages on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            fix_q <= '0;
            pre_q <= '0;
        end else if (en_i) begin
            fix_q <= fix_q + 1'b1;
            if (fix_wrap)
                pre_q <= (pre_q == reload_i) ? '0 : pre_q + 1'b1;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(fix_q) && $stable(pre_q)));
endmodule

// File: rtl/tmr_edge_sync.sv
// Synchronises an asynchronous input through a flop chain and flags each
// rising edge with a one-cycle pulse. Assumes input pulses last >= 2 clocks.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] && !prev_q;

    // R5
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_count_core.sv
// The two count halves. In split use each half matches on its own; in wide
// use they form one count with the high half as upper byte. Assumes the
// increment selection per mode is done by the caller.
module tmr_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         wide_i,
    input  logic         inc_lo_i,
    input  logic         inc_hi_i,
    input  logic [W-1:0] match_lo_i,
    input  logic [W-1:0] match_hi_i,
    output logic         hit_lo_o,
    output logic         hit_hi_o
);
    localparam int WW = 2 * W;

    logic [W-1:0]  lo_q, hi_q, lo_n, hi_n;
    logic [WW-1:0] wide_cnt, wide_nxt;
    logic          lo_hit, hi_hit, w_hit;

    assign wide_cnt = {hi_q, lo_q};

    // Compute the next counts and match pulses for the active arrangement.
    always_comb begin
        lo_hit   = inc_lo_i && (lo_q == match_lo_i);
        hi_hit   = inc_hi_i && (hi_q == match_hi_i);
        w_hit    = inc_lo_i && (wide_cnt == {match_hi_i, match_lo_i});
        wide_nxt = w_hit ? '0 : (inc_lo_i ? wide_cnt + 1'b1 : wide_cnt);
        if (wide_i) begin
            {hi_n, lo_n} = wide_nxt;
            hit_lo_o     = 1'b0;
            hit_hi_o     = w_hit;
        end else begin
            lo_n     = lo_hit ? '0 : (inc_lo_i ? lo_q + 1'b1 : lo_q);
            hi_n     = hi_hit ? '0 : (inc_hi_i ? hi_q + 1'b1 : hi_q);
            hit_lo_o = lo_hit;
            hit_hi_o = hi_hit;
        end
    end

    // Register the count halves; a clear overrides counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (lo_q == '0 && hi_q == '0));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_lo_i && !inc_hi_i && !clr_i) |=> ($stable(lo_q) && $stable(hi_q)));
    // R3
    hit_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lo_o && !clr_i && !wide_i) |=> (lo_q == '0));
endmodule

// File: rtl/dual_byte_timer.sv
// Multi-mode 16-bit timer/counter top. Holds the configuration registers,
// routes prescaler ticks and synchronised events to the halves per mode and
// keeps the write-one-to-clear interrupt flags. Assumes wr_* are synchronous.
module dual_byte_timer
    import tmr_pkg::*;
#(
    parameter int FIX_W  = 2,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              ext_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              irq_lo,
    output logic              irq_hi
);
    tmr_mode_e         mode_q;
    logic [BYTE_W-1:0] reload_q, mlo_q, mhi_q;
    logic              run_q, flag_lo_q, flag_hi_q;
    logic              ctrl_wr, clr_all, tick, evt, evt_run;
    logic              inc_lo, inc_hi, hit_lo, hit_hi, wide;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign clr_all = ctrl_wr;

    // Configuration registers; a control write also stops the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_SPLIT;
            reload_q <= '0;
            mlo_q    <= '0;
            mhi_q    <= '0;
            run_q    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    mode_q <= tmr_mode_e'(wr_data[1:0]);
                    run_q  <= 1'b0;
                end
                A_RELOAD: reload_q <= wr_data;
                A_MLO:    mlo_q    <= wr_data;
                A_MHI:    mhi_q    <= wr_data;
                A_RUN:    run_q    <= wr_data[0];
                default:  ;
            endcase
        end
    end

    tmr_prescaler #(.FIX_W(FIX_W), .PRE_W(BYTE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en_i(cyc_en && run_q), .clr_i(clr_all),
        .reload_i(reload_q), .tick_o(tick)
    );

    tmr_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_evt), .rise_o(evt)
    );

    assign evt_run = evt && run_q;
    assign wide    = mode_q[1];

    // Route tick and event sources to the halves for the selected mode.
    always_comb begin
        case (mode_q)
            MODE_SPLIT:  begin inc_lo = tick;    inc_hi = tick;    end
            MODE_MIXED:  begin inc_lo = tick;    inc_hi = evt_run; end
            MODE_WIDE_T: begin inc_lo = tick;    inc_hi = 1'b0;    end
            default:     begin inc_lo = evt_run; inc_hi = 1'b0;    end
        endcase
    end

    tmr_count_core #(.W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_all), .wide_i(wide),
        .inc_lo_i(inc_lo), .inc_hi_i(inc_hi),
        .match_lo_i(mlo_q), .match_hi_i(mhi_q),
        .hit_lo_o(hit_lo), .hit_hi_o(hit_hi)
    );

    // Interrupt flags: set by a match, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_lo_q <= 1'b0;
            flag_hi_q <= 1'b0;
        end else begin
            if (hit_lo)
                flag_lo_q <= 1'b1;
            else if (wr_en && wr_addr == A_FCLR && wr_data[0])
                flag_lo_q <= 1'b0;
            if (hit_hi)
                flag_hi_q <= 1'b1;
            else if (wr_en && wr_addr == A_FCLR && wr_data[1])
                flag_hi_q <= 1'b0;
        end
    end

    assign irq_lo = flag_lo_q;
    assign irq_hi = flag_hi_q;

    // R3
    lo_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lo) |-> $past(hit_lo));
    // R6
    wide_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !irq_lo) |=> !irq_lo);
    // R9
    hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FCLR && wr_data[1] && !hit_hi) |=> !irq_hi);
    // R11
    stopped_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!hit_lo && !hit_hi));
endmodule

// File: tb/test_dual_byte_timer.sv
module test_dual_byte_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b1;
    logic       ext_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_lo, irq_hi;
    logic       half_rate = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    dual_byte_timer i_dual_byte_timer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_evt(ext_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    initial forever begin
        @(negedge clk);
        cyc_en = half_rate ? ~cyc_en : 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk); ext_evt = 1'b1;
        repeat (3) @(negedge clk);
        ext_evt = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Count edges (or enabled edges) from the run write until a flag rises.
    task automatic measure(input bit hi, input int limit, input bit en_only, output int n);
        int cnt = 0;
        n = -1;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk); #1;
            if (!en_only || cyc_en) cnt++;
            if ((hi ? irq_hi : irq_lo) && n < 0) begin n = cnt; break; end
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic [7:0] p,
                         input logic [7:0] ml, input logic [7:0] mh);
        wr(3'd0, {6'd0, m});
        wr(3'd1, p); wr(3'd2, ml); wr(3'd3, mh);
        wr(3'd4, 8'h03);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 irq_lo after reset", irq_lo, 0);
        chk("R1 irq_hi after reset", irq_hi, 0);
        repeat (40) @(posedge clk);
        #1;
        chk("R1 stopped after reset", irq_lo | irq_hi, 0);
    endtask

    task automatic t_split();
        int n;
        setup(2'd0, 8'd0, 8'd2, 8'd4);
        wr(3'd5, 8'd1);
        measure(1'b0, 100, 1'b0, n);
        chk("R4 low half first match", n, 12);
        measure(1'b1, 100, 1'b0, n);
        chk("R4 high half first match (extra)", n, 8);
        setup(2'd0, 8'd2, 8'd1, 8'd200);
        wr(3'd5, 8'd1);
        measure(1'b0, 200, 1'b0, n);
        chk("R2 reload 2 period", n, 24);
    endtask

    task automatic t_half_rate();
        int n;
        setup(2'd0, 8'd0, 8'd2, 8'd200);
        half_rate = 1'b1;
        wr(3'd5, 8'd1);
        measure(1'b0, 200, 1'b1, n);
        chk("R2 only enabled cycles count", n, 12);
        half_rate = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_mixed();
        int n;
        setup(2'd1, 8'd0, 8'd2, 8'd2);
        wr(3'd5, 8'd1);
        measure(1'b0, 100, 1'b0, n);
        chk("R5 low half is timer", n, 12);
        repeat (100) @(posedge clk);
        #1;
        chk("R5 ticks do not move high half", irq_hi, 0);
        pulse_evt(); pulse_evt();
        chk("R5 two events below match", irq_hi, 0);
        pulse_evt();
        chk("R5 third event matches", irq_hi, 1);
    endtask

    task automatic t_wide_timer();
        int n;
        setup(2'd2, 8'd0, 8'd2, 8'd1);
        wr(3'd5, 8'd1);
        measure(1'b1, 2000, 1'b0, n);
        chk("R6 16-bit timer match", n, 1036);
        chk("R6 low flag silent", irq_lo, 0);
    endtask

    task automatic t_wide_counter();
        setup(2'd3, 8'd0, 8'd0, 8'd1);
        wr(3'd5, 8'd1);
        for (int i = 0; i < 256; i++) pulse_evt();
        chk("R7 256 events below match", irq_hi, 0);
        repeat (200) @(posedge clk);
        #1;
        chk("R7 ticks ignored at match", irq_hi, 0);
        pulse_evt();
        chk("R7 257th event matches", irq_hi, 1);
        chk("R7 low flag silent", irq_lo, 0);
    endtask

    task automatic t_wrap();
        int first = -1;
        setup(2'd1, 8'd255, 8'd255, 8'd20);
        wr(3'd5, 8'd1);
        for (int i = 0; i < 10; i++) pulse_evt();
        wr(3'd3, 8'd3);
        for (int i = 1; i <= 260; i++) begin
            pulse_evt();
            if (irq_hi && first < 0) first = i;
        end
        chk("R8 wrap past all ones then match", first, 250);
    endtask

    task automatic t_flags();
        setup(2'd0, 8'd0, 8'd0, 8'd0);
        wr(3'd5, 8'd1);
        repeat (6) @(posedge clk);
        wr(3'd5, 8'd0);
        chk("R9 both set before clear", irq_lo + irq_hi, 2);
        wr(3'd4, 8'h00);
        chk("R9 zero bits keep flags", irq_lo + irq_hi, 2);
        wr(3'd4, 8'h01);
        chk("R9 clear low only lo", irq_lo, 0);
        chk("R9 clear low keeps hi", irq_hi, 1);
        wr(3'd4, 8'h02);
        chk("R9 clear high", irq_hi, 0);
    endtask

    task automatic t_mode_clear();
        int n;
        setup(2'd0, 8'd0, 8'd2, 8'd200);
        wr(3'd5, 8'd1);
        repeat (6) @(posedge clk);
        wr(3'd0, 8'd0);
        repeat (40) @(posedge clk);
        #1;
        chk("R10 control write stops", irq_lo, 0);
        wr(3'd5, 8'd1);
        measure(1'b0, 100, 1'b0, n);
        chk("R10 control write clears counts", n, 12);
        wr(3'd0, 8'd0);
        chk("R10 flags kept on control write", irq_lo, 1);
    endtask

    task automatic t_hold();
        int n;
        setup(2'd0, 8'd0, 8'd2, 8'd200);
        wr(3'd5, 8'd1);
        repeat (6) @(posedge clk);
        wr(3'd5, 8'd0);
        repeat (40) @(posedge clk);
        #1;
        chk("R11 no flag while stopped", irq_lo, 0);
        wr(3'd5, 8'd1);
        measure(1'b0, 100, 1'b0, n);
        chk("R11 resume from held state", n, 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_split();
        t_half_rate();
        t_mixed();
        t_wide_timer();
        t_wide_counter();
        t_wrap();
        t_flags();
        t_mode_clear();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule